// File: doc/BRIEF.md
# Angle Readout Port for a Tracking Converter

This block links the angle counter of a tracking converter to a host bus. Step requests from the tracking loop move a 14-bit angle counter up or down by one count. Each step produces a busy pulse of fixed width, and the counter changes halfway through that pulse. A fixed idle time follows every pulse before the next one may start. A step that arrives while a pulse or its idle time is running is kept in a single pending slot. It is serviced as soon as the sequencer can take it.

The host reads the angle through a holding stage. While the active-low hold input is high, the stage is transparent. Pulling the hold input low freezes the presented word, and the counter keeps moving underneath. A hold that arrives during a busy pulse waits for the pulse to end, so the frozen word is never caught mid-update.

Two active-low enables steer the word onto a 16-lane bus, with a lane-enable vector standing in for the tri-state drivers:
- The upper enable alone puts the 8 most significant bits on the low byte lanes.
- The lower enable alone puts the 6 least significant bits on the low byte lanes.
- Both enables together present the whole word across 16 lanes.

Top module: `angle_readout`

## Requirements
- R1: After reset the busy output is low, the counter is 0, the holding stage is transparent, and with both enables high every lane-enable bit and every data lane is 0.
- R2: An accepted step request raises busy on the next clock edge for exactly BUSY_CYC cycles (default 4). The counter moves by one count, up when the direction input is 1 and down when it is 0, on the edge that ends the BUSY_CYC/2-th busy cycle.
- R3: Busy stays low for at least GAP_CYC cycles (default 2) between pulses. A request that arrives while busy or idle time is running is held in one pending slot and serviced at the end of the idle time. A further request while the slot is full is discarded.
- R4: When the hold input is low and busy is low at a clock edge, the presented word freezes from that edge on. It stays constant while the counter keeps changing.
- R5: A hold that arrives while busy is high takes effect only at the first edge at which busy is low. The frozen word then carries the update made inside that pulse.
- R6: When the hold input returns high, the holding stage is transparent again after the next clock edge, and the presented word equals the counter.
- R7: With only the upper enable low, lanes 7..0 carry word bits 13..6, and lane enables 7..0 are 1 while lane enables 15..8 are 0.
- R8: With only the lower enable low, lanes 5..0 carry word bits 5..0, lanes 7..6 are driven to 0, and only lane enables 7..0 are 1.
- R9: With both enables low, lanes 15..8 carry word bits 13..6, lanes 7..6 are 0, lanes 5..0 carry word bits 5..0, and all 16 lane enables are 1.
- R10: With both enables high, all lane enables and all data lanes are 0.
- R11: The counter wraps modulo 2^14: a down step from 0 gives 16383 and an up step from 16383 gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_i | input | 1 | Step request from the tracking loop |
| step_up_i | input | 1 | Step direction, 1 counts up |
| hold_n_i | input | 1 | Active-low freeze request for the presented word |
| en_hi_n_i | input | 1 | Active-low upper-part read enable |
| en_lo_n_i | input | 1 | Active-low lower-part read enable |
| busy_o | output | 1 | Counter-update pulse |
| angle_o | output | 14 | Live counter value |
| bus_d_o | output | 16 | Data lanes toward the host bus |
| bus_oe_o | output | 16 | Per-lane drive enable, 0 means high impedance |

## Verification
The hardest case to reach from the ports is a hold request landing inside a busy pulse, before the counter update in the middle of that pulse. The bench issues a single step from an idle state and waits one clock until busy is seen high. It then drops the hold input at once, so the request is pending across the update edge and the end of the pulse. A second hard case is the pending slot overflowing. The bench reaches it by keeping the step request high on three consecutive cycles, and by holding it high across long streams while the word is frozen.

// File: rtl/angle_readout_pkg.sv
package angle_readout_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_BUSY = 2'd1,
    SEQ_GAP  = 2'd2
  } seq_state_t;

  typedef enum logic [1:0] {
    LANE_OFF  = 2'd0,
    LANE_HI   = 2'd1,
    LANE_LO   = 2'd2,
    LANE_WIDE = 2'd3
  } lane_mode_t;

  // Decode the two active-low enables into a steering mode.
  function automatic lane_mode_t lane_mode(input logic hi_n, input logic lo_n);
    case ({hi_n, lo_n})
      2'b01:   return LANE_HI;
      2'b10:   return LANE_LO;
      2'b00:   return LANE_WIDE;
      default: return LANE_OFF;
    endcase
  endfunction

endpackage

// File: rtl/angle_readout_seq.sv
module angle_readout_seq
  import angle_readout_pkg::*;
#(
  parameter int ANG_W    = 14,
  parameter int BUSY_CYC = 4,
  parameter int GAP_CYC  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic             up_i,
  output logic             busy_o,
  output logic             mid_evt_o,
  output logic [ANG_W-1:0] angle_o
);
  localparam int HALF  = BUSY_CYC / 2;
  localparam int CMAX  = (BUSY_CYC > GAP_CYC) ? BUSY_CYC : GAP_CYC;
  localparam int CW    = $clog2(CMAX + 1);

  function automatic logic [ANG_W-1:0] next_angle(input logic [ANG_W-1:0] a, input logic up);
    return up ? (a + ANG_W'(1)) : (a - ANG_W'(1));
  endfunction

  seq_state_t       st_q;
  logic [CW-1:0]    cnt_q;
  logic             pend_q, pend_up_q, dir_q;
  logic [ANG_W-1:0] ang_q;

  logic busy_last, gap_last, can_take, take, take_up;

  assign busy_last = (st_q == SEQ_BUSY) && (cnt_q == CW'(BUSY_CYC - 1));
  assign gap_last  = (st_q == SEQ_GAP)  && (cnt_q == CW'(GAP_CYC - 1));
  assign can_take  = (st_q == SEQ_IDLE) || gap_last;
  assign take      = can_take && (step_i || pend_q);
  assign take_up   = pend_q ? pend_up_q : up_i;
  assign mid_evt_o = (st_q == SEQ_BUSY) && (cnt_q == CW'(HALF - 1));
  assign busy_o    = (st_q == SEQ_BUSY);
  assign angle_o   = ang_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= SEQ_IDLE;
      cnt_q <= '0;
      dir_q <= 1'b1;
    end else begin
      case (st_q)
        SEQ_IDLE: begin
          if (take) begin
            st_q  <= SEQ_BUSY;
            cnt_q <= '0;
            dir_q <= take_up;
          end
        end
        SEQ_BUSY: begin
          if (busy_last) begin
            st_q  <= SEQ_GAP;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        SEQ_GAP: begin
          if (gap_last) begin
            cnt_q <= '0;
            if (take) begin
              st_q  <= SEQ_BUSY;
              dir_q <= take_up;
            end else begin
              st_q <= SEQ_IDLE;
            end
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        default: st_q <= SEQ_IDLE;
      endcase
    end
  end

  // One-deep pending slot: a request that cannot be taken waits here.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      pend_up_q <= 1'b1;
    end else if (take) begin
      if (pend_q) begin
        pend_q    <= step_i;
        pend_up_q <= up_i;
      end
    end else if (step_i && !pend_q) begin
      pend_q    <= 1'b1;
      pend_up_q <= up_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         ang_q <= '0;
    else if (mid_evt_o) ang_q <= next_angle(ang_q, dir_q);
  end

  // Run-length counters used only by the checks below.
  logic [15:0] hi_run_q, lo_run_q;
  logic        seen_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_run_q <= '0;
      lo_run_q <= '0;
      seen_q   <= 1'b0;
    end else begin
      hi_run_q <= busy_o ? ((hi_run_q == 16'hFFFF) ? hi_run_q : hi_run_q + 16'd1) : 16'd0;
      lo_run_q <= busy_o ? 16'd0 : ((lo_run_q == 16'hFFFF) ? lo_run_q : lo_run_q + 16'd1);
      if (busy_o) seen_q <= 1'b1;
    end
  end

  p_busy_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (int'(hi_run_q) == BUSY_CYC));

  p_gap_min_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy_o) && seen_q) |-> (int'(lo_run_q) >= GAP_CYC));

  p_angle_in_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(angle_o) |-> (busy_o && $past(busy_o)));

  p_angle_unit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(angle_o) |-> ((angle_o == $past(angle_o) + ANG_W'(1)) ||
                           (angle_o == $past(angle_o) - ANG_W'(1))));

endmodule

// File: rtl/angle_readout_hold.sv
module angle_readout_hold #(
  parameter int ANG_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_n_i,
  input  logic             busy_i,
  input  logic [ANG_W-1:0] angle_i,
  output logic             freeze_o,
  output logic             defer_o,
  output logic [ANG_W-1:0] word_o
);
  logic             frz_q;
  logic [ANG_W-1:0] held_q;

  // Arbitration: a hold request is honoured only on an edge with busy low.
  always_ff @(posedge clk) begin
    if (!rst_n)        frz_q <= 1'b0;
    else if (hold_n_i) frz_q <= 1'b0;
    else if (!busy_i)  frz_q <= 1'b1;
  end

  // Holding register tracks the counter until a freeze is in force.
  always_ff @(posedge clk) begin
    if (!rst_n)      held_q <= '0;
    else if (!frz_q) held_q <= angle_i;
  end

  assign freeze_o = frz_q;
  assign defer_o  = !hold_n_i && busy_i && !frz_q;
  assign word_o   = frz_q ? held_q : angle_i;

  p_freeze_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(freeze_o) |-> !$past(busy_i));

  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hold_n_i) |-> !freeze_o);

  p_hold_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze_o && $past(freeze_o)) |-> $stable(word_o));

endmodule

// File: rtl/angle_readout_steer.sv
module angle_readout_steer
  import angle_readout_pkg::*;
#(
  parameter int ANG_W  = 14,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en_hi_n_i,
  input  logic                en_lo_n_i,
  input  logic [ANG_W-1:0]    word_i,
  output logic [2*BYTE_W-1:0] bus_d_o,
  output logic [2*BYTE_W-1:0] bus_oe_o
);
  localparam int LO_W = ANG_W - BYTE_W;

  function automatic logic [BYTE_W-1:0] upper_part(input logic [ANG_W-1:0] w);
    return w[ANG_W-1 -: BYTE_W];
  endfunction

  function automatic logic [BYTE_W-1:0] lower_part(input logic [ANG_W-1:0] w);
    return BYTE_W'(w[LO_W-1:0]);
  endfunction

  lane_mode_t mode;
  assign mode = lane_mode(en_hi_n_i, en_lo_n_i);

  always_comb begin
    bus_d_o  = '0;
    bus_oe_o = '0;
    case (mode)
      LANE_HI: begin
        bus_d_o[BYTE_W-1:0]  = upper_part(word_i);
        bus_oe_o[BYTE_W-1:0] = '1;
      end
      LANE_LO: begin
        bus_d_o[BYTE_W-1:0]  = lower_part(word_i);
        bus_oe_o[BYTE_W-1:0] = '1;
      end
      LANE_WIDE: begin
        bus_d_o  = {upper_part(word_i), lower_part(word_i)};
        bus_oe_o = '1;
      end
      default: ;
    endcase
  end

  p_off_lanes_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en_hi_n_i && en_lo_n_i) |-> ((bus_oe_o == '0) && (bus_d_o == '0)));

  p_byte_lanes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_hi_n_i ^ en_lo_n_i) |-> (bus_oe_o[2*BYTE_W-1:BYTE_W] == '0) && (&bus_oe_o[BYTE_W-1:0]));

  p_low_pad_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_lo_n_i && en_hi_n_i) |-> (bus_d_o[2*BYTE_W-1:LO_W] == '0));

endmodule

// File: rtl/angle_readout.sv
module angle_readout #(
  parameter int ANG_W    = 14,
  parameter int BYTE_W   = 8,
  parameter int BUSY_CYC = 4,
  parameter int GAP_CYC  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step_i,
  input  logic                step_up_i,
  input  logic                hold_n_i,
  input  logic                en_hi_n_i,
  input  logic                en_lo_n_i,
  output logic                busy_o,
  output logic [ANG_W-1:0]    angle_o,
  output logic [2*BYTE_W-1:0] bus_d_o,
  output logic [2*BYTE_W-1:0] bus_oe_o
);
  logic             busy, mid_evt, freeze, defer;
  logic [ANG_W-1:0] angle, word;

  angle_readout_seq #(.ANG_W(ANG_W), .BUSY_CYC(BUSY_CYC), .GAP_CYC(GAP_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .step_i(step_i), .up_i(step_up_i),
    .busy_o(busy), .mid_evt_o(mid_evt), .angle_o(angle)
  );

  angle_readout_hold #(.ANG_W(ANG_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .hold_n_i(hold_n_i), .busy_i(busy),
    .angle_i(angle), .freeze_o(freeze), .defer_o(defer), .word_o(word)
  );

  angle_readout_steer #(.ANG_W(ANG_W), .BYTE_W(BYTE_W)) u_steer (
    .clk(clk), .rst_n(rst_n), .en_hi_n_i(en_hi_n_i), .en_lo_n_i(en_lo_n_i),
    .word_i(word), .bus_d_o(bus_d_o), .bus_oe_o(bus_oe_o)
  );

  assign busy_o  = busy;
  assign angle_o = angle;

  p_defer_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
    defer |=> !$rose(freeze));

  p_mid_in_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mid_evt |-> busy);

endmodule

// File: tb/angle_readout_bench.sv
module angle_readout_bench;
  localparam int ANG_W    = 14;
  localparam int BUSY_CYC = 4;
  localparam int GAP_CYC  = 2;
  localparam int HALF     = BUSY_CYC / 2;
  localparam int MODV     = 1 << ANG_W;
  localparam int WDOG     = 100000;

  logic clk = 1'b0, rst_n = 1'b0, step = 1'b0, up = 1'b1;
  logic hold_n = 1'b1, en_hi_n = 1'b1, en_lo_n = 1'b1;
  wire        busy;
  wire [13:0] ang;
  wire [15:0] bd, boe;

  angle_readout u_angle_readout (
    .clk(clk), .rst_n(rst_n), .step_i(step), .step_up_i(up), .hold_n_i(hold_n),
    .en_hi_n_i(en_hi_n), .en_lo_n_i(en_lo_n), .busy_o(busy), .angle_o(ang),
    .bus_d_o(bd), .bus_oe_o(boe)
  );

  always #2 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, pulses = 0;
  int hi_run = 0, lo_run = 0, exp_ang = 0;
  bit done = 1'b0, seen = 1'b0, prev_busy = 1'b0;
  int prev_ang = 0;

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  function automatic int wide(input int w);
    return (w / 64) * 256 + (w % 64);
  endfunction

  function automatic int exp_d(input int w, input int e);
    case (e)
      0: return wide(w);
      1: return w / 64;
      2: return w % 64;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_oe(input int e);
    case (e)
      0: return 16'hFFFF;
      1, 2: return 16'h00FF;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG && !done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1-all got %0d cycles expected %0d", cyc, WDOG);
      finish_run();
    end
  end

  // Pulse-shape monitor: widths, gaps and the position of the counter update.
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) begin
        hi_run++;
        if (!prev_busy) begin
          pulses++;
          if (seen) chk("R3 idle gap between pulses", int'(lo_run >= GAP_CYC), 1);
          seen = 1'b1;
        end
      end else if (prev_busy) begin
        chk("R2 busy width", hi_run, BUSY_CYC);
      end
      if (int'(ang) != prev_ang) begin
        chk("R2 update position in pulse", int'(busy) * hi_run, HALF + 1);
        chk("R11 unit step", int'((((int'(ang) - prev_ang) + MODV) % MODV == 1) ||
                                  (((int'(ang) - prev_ang) + MODV) % MODV == MODV - 1)), 1);
      end
      if (!busy) hi_run = 0;
      lo_run    = busy ? 0 : lo_run + 1;
      prev_busy = busy;
      prev_ang  = int'(ang);
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic quiet();
    int q = 0;
    while (q < GAP_CYC + 3) begin
      tick();
      q = busy ? 0 : q + 1;
    end
  endtask

  task automatic do_step(input bit d);
    step = 1'b1;
    up   = d;
    tick();
    step = 1'b0;
    quiet();
    exp_ang = d ? (exp_ang + 1) % MODV : (exp_ang + MODV - 1) % MODV;
  endtask

  task automatic sweep_bus(input string tag);
    for (int e = 0; e < 4; e++) begin
      en_hi_n = e[1];
      en_lo_n = e[0];
      #1;
      chk({tag, " data"}, int'(bd), exp_d(exp_ang, e));
      chk({tag, " lane enables"}, int'(boe), exp_oe(e));
    end
    en_hi_n = 1'b0;
    en_lo_n = 1'b0;
  endtask

  initial begin
    int p0;
    int frozen;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk("R1 busy after reset", int'(busy), 0);
    chk("R1 counter after reset", int'(ang), 0);
    chk("R1 lane enables idle", int'(boe), 0);
    chk("R10 data lanes idle", int'(bd), 0);
    en_hi_n = 1'b0;
    en_lo_n = 1'b0;
    #1;
    chk("R1 transparent word", int'(bd), 0);
    tick();

    // R2 single up step
    do_step(1'b1);
    chk("R2 counter after up step", int'(ang), exp_ang);

    // R11 wrap below zero
    do_step(1'b0);
    do_step(1'b0);
    chk("R11 wrap down", int'(ang), MODV - 1);
    sweep_bus("R9 R7 R8 R10 at top value");

    // R3 three back-to-back requests: one taken, one pending, one dropped
    p0 = pulses;
    step = 1'b1;
    up   = 1'b1;
    repeat (3) tick();
    step = 1'b0;
    quiet();
    chk("R3 pulse count with pending and drop", pulses - p0, 2);
    exp_ang = (exp_ang + 2) % MODV;
    chk("R3 counter after pending service", int'(ang), exp_ang);
    chk("R11 wrap up", int'(ang), 1);

    // R7 R8 R9 R10 steering sweep over a run of counter values
    for (int k = 0; k < 70; k++) begin
      do_step(1'b1);
      sweep_bus("R7 R8 R9 R10 sweep");
    end
    for (int k = 0; k < 8; k++) begin
      do_step(k[0]);
      do_step(1'b0);
      sweep_bus("R8 R9 sweep down");
    end

    // R4 freeze while idle, counter streams underneath
    frozen = exp_ang;
    hold_n = 1'b0;
    tick();
    chk("R4 frozen at request", int'(bd), wide(frozen));
    p0   = pulses;
    step = 1'b1;
    up   = 1'b1;
    for (int k = 0; k < 40; k++) begin
      tick();
      chk("R4 word held while counting", int'(bd), wide(frozen));
    end
    step = 1'b0;
    quiet();
    exp_ang = (exp_ang + (pulses - p0)) % MODV;
    chk("R4 counter moved under freeze", int'(ang), exp_ang);
    chk("R4 counter differs from held", int'(int'(ang) != frozen), 1);
    chk("R4 word still held", int'(bd), wide(frozen));

    // R6 release: still held before the edge, transparent after it
    hold_n = 1'b1;
    #1;
    chk("R6 held until next edge", int'(bd), wide(frozen));
    tick();
    chk("R6 transparent after release", int'(bd), wide(exp_ang));
    do_step(1'b1);
    chk("R6 follows counter after release", int'(bd), wide(exp_ang));

    // R5 hold requested inside a busy pulse, before the mid-pulse update
    step = 1'b1;
    up   = 1'b1;
    tick();
    step = 1'b0;
    chk("R5 busy seen before hold", int'(busy), 1);
    hold_n = 1'b0;
    frozen = (exp_ang + 1) % MODV;
    quiet();
    exp_ang = frozen;
    chk("R5 frozen word carries update", int'(bd), wide(frozen));
    do_step(1'b1);
    do_step(1'b1);
    chk("R5 word stays after later steps", int'(bd), wide(frozen));
    chk("R5 counter kept moving", int'(ang), exp_ang);
    hold_n = 1'b1;
    tick();
    chk("R6 transparent after deferred hold", int'(bd), wide(exp_ang));

    // R10 both enables high again
    en_hi_n = 1'b1;
    en_lo_n = 1'b1;
    #1;
    chk("R10 lanes released", int'(boe), 0);
    chk("R10 data zero", int'(bd), 0);
    tick();
    finish_run();
  end

endmodule